// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch

This block picks the system clock from several independent, free-running clock inputs. A source-select code chooses the input. A change of code never puts a runt pulse or a glitch on the output. The block first gates the outgoing clock off while that clock is low. It then holds the output low for a fixed pause, counted in periods of the incoming clock. Last, it gates the incoming clock on, also while that clock is low. Every phase of the output is therefore a whole phase of one of the source clocks.

A small controller runs on the default source clock. It synchronizes the select code, fixes the target source and raises a busy flag for the length of a handover. Each source has a lane clocked by that source. The lane synchronizes its enable request and the "another source is live" status into its own domain. It counts the pause and moves its gate only on its own falling edge. The output is the OR of the gated clocks. After reset the default source drives the output at once, with no pause.

Top module: `glitchless_clk_switch`

## Requirements
- R1: While reset is asserted and after it is released, the default source (index 0 by default) drives `clk_o` with no pause, and `busy_o` is 0.
- R2: At most one source is gated onto the output at any time. No high or low phase of `clk_o` is shorter than the shorter half-period of the outgoing and incoming sources.
- R3: During a switch, `clk_o` stays low from the last falling edge of the old source until a rising edge of the new source. That low time is at least 8 and at most 9 periods of the new source.
- R4: After a switch, `clk_o` runs at the period of the newly selected source.
- R5: `busy_o` rises within 3 default-clock periods after a select change to a different valid source. It falls only after the new source has produced its first rising edge on `clk_o`.
- R6: A select change that arrives while a switch is in progress does not disturb that switch. The block performs it as a separate switch once the current one completes.
- R7: A select code equal to the current source causes no busy flag and no pause.
- R8: A select code of value `NUM_CLK` or above is ignored: no busy flag, no pause, and the output keeps its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | NUM_CLK | Candidate source clocks, bit i is source i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | SEL_W | Requested source index, held stable while changing |
| clk_o | output | 1 | Switched system clock |
| busy_o | output | 1 | High while a handover is in progress (default-clock domain) |

## Verification
The busy flag crosses two select synchronizer stages and one controller register, so it is due within 3 default-clock periods of a select change. The bench samples it 14 ns after the change, on a quarter-nanosecond offset that never coincides with a clock edge. The pause and the new period are measured from the edges of `clk_o` itself, with real-time stamps. The expected window of 8 to 9 new-clock periods is computed from the clock periods the bench generates. Release of the busy flag is awaited with a bounded poll, and the pause counter must already have advanced by then. Each pending-select case gets a fixed 3 µs window to finish both handovers before the check.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    LANE_IDLE = 2'd0,
    LANE_WAIT = 2'd1,
    LANE_LIVE = 2'd2
  } lane_st_e;
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/clksw_lane.sv
module clksw_lane
  import clksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CNT    = 6,
  parameter bit IS_DEF      = 1'b0,
  localparam int CNT_W      = (WAIT_CNT > 1) ? $clog2(WAIT_CNT + 1) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic others_on_i,
  output logic gate_o
);
  lane_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             req_s;
  logic             others_s;
  logic             gate_q;

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IS_DEF)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_oth_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (others_on_i),
    .q_o   (others_s)
  );

  // Pause = sync stages + WAIT_CNT cycles of this clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= IS_DEF ? LANE_LIVE : LANE_IDLE;
      cnt_q <= IS_DEF ? CNT_W'(WAIT_CNT) : '0;
    end else if (!req_s) begin
      st_q  <= LANE_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        LANE_IDLE: begin
          if (!others_s) begin
            if (WAIT_CNT <= 1) begin
              st_q  <= LANE_LIVE;
              cnt_q <= CNT_W'(WAIT_CNT);
            end else begin
              st_q  <= LANE_WAIT;
              cnt_q <= CNT_W'(1);
            end
          end
        end
        LANE_WAIT: begin
          if (others_s) begin
            st_q  <= LANE_IDLE;
            cnt_q <= '0;
          end else if (cnt_q == CNT_W'(WAIT_CNT - 1)) begin
            st_q  <= LANE_LIVE;
            cnt_q <= CNT_W'(WAIT_CNT);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        LANE_LIVE: ;
        default: begin
          st_q  <= LANE_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  // Gate moves only while this clock is low.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= IS_DEF;
    else         gate_q <= (st_q == LANE_LIVE);
  end

  assign gate_o = gate_q;

  assert_arm_after_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) |-> (cnt_q == CNT_W'(WAIT_CNT)));

  assert_no_overlap_on_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) |-> !others_on_i);
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl #(
  parameter int NUM_CLK     = 3,
  parameter int DEF_SRC     = 0,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_CLK-1:0] gate_i,
  output logic [NUM_CLK-1:0] tgt_oh_o,
  output logic               busy_o
);
  logic [SEL_W-1:0]   sel_m_q, sel_s_q, tgt_q;
  logic [NUM_CLK-1:0] gate_s;
  logic [NUM_CLK-1:0] tgt_oh;
  logic               busy_q;
  logic               sel_stable, sel_valid, start, done;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_stat_sync
    clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(g == DEF_SRC)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (gate_i[g]),
      .q_o   (gate_s[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_m_q <= SEL_W'(DEF_SRC);
      sel_s_q <= SEL_W'(DEF_SRC);
    end else begin
      sel_m_q <= sel_i;
      sel_s_q <= sel_m_q;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CLK; i++) tgt_oh[i] = (int'(tgt_q) == i);
  end

  assign sel_stable = (sel_m_q == sel_s_q);
  assign sel_valid  = (int'(sel_s_q) < NUM_CLK);
  assign start      = !busy_q && sel_stable && sel_valid && (sel_s_q != tgt_q);
  assign done       = busy_q && (gate_s == tgt_oh);

  // A later request waits in the select synchronizer until the switch ends.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= SEL_W'(DEF_SRC);
      busy_q <= 1'b0;
    end else if (start) begin
      tgt_q  <= sel_s_q;
      busy_q <= 1'b1;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  assign tgt_oh_o = tgt_oh;
  assign busy_o   = busy_q;

  assert_tgt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !done) |=> $stable(tgt_q));

  assert_tgt_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tgt_q) < NUM_CLK);

  assert_idle_running_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (gate_s == tgt_oh));
endmodule

// File: rtl/glitchless_clk_switch.sv
module glitchless_clk_switch #(
  parameter int NUM_CLK     = 3,
  parameter int DEF_SRC     = 0,
  parameter int SYNC_STAGES = 2,
  parameter int PAUSE_CYC   = 8,
  localparam int SEL_W      = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic [NUM_CLK-1:0] clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               clk_o,
  output logic               busy_o
);
  localparam int WAIT_CNT = PAUSE_CYC - SYNC_STAGES;

  logic [NUM_CLK-1:0] gate_w;
  logic [NUM_CLK-1:0] req_w;
  logic [NUM_CLK-1:0] others_w;

  clksw_ctrl #(
    .NUM_CLK    (NUM_CLK),
    .DEF_SRC    (DEF_SRC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk_i   (clk_i[DEF_SRC]),
    .rst_ni  (rst_ni),
    .sel_i   (sel_i),
    .gate_i  (gate_w),
    .tgt_oh_o(req_w),
    .busy_o  (busy_o)
  );

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_lane
    assign others_w[g] = |(gate_w & ~(NUM_CLK'(1) << g));

    clksw_lane #(
      .SYNC_STAGES(SYNC_STAGES),
      .WAIT_CNT   (WAIT_CNT),
      .IS_DEF     (g == DEF_SRC)
    ) u_lane (
      .clk_i      (clk_i[g]),
      .rst_ni     (rst_ni),
      .req_i      (req_w[g]),
      .others_on_i(others_w[g]),
      .gate_o     (gate_w[g])
    );
  end

  assign clk_o = |(clk_i & gate_w);

  assert_single_gate_R2: assert property (@(posedge clk_i[DEF_SRC]) disable iff (!rst_ni)
    $onehot0(gate_w));
endmodule

// File: tb/glitchless_clk_switch_tb.sv
`timescale 1ns/1ps
module glitchless_clk_switch_tb;
  localparam int N = 3;

  logic [N-1:0] clk_i;
  logic         rst_ni;
  logic [1:0]   sel_i;
  logic         clk_o;
  logic         busy_o;

  int  checks, errors, pause_cnt, cur;
  real last_pause, floor_w, t_rise, t_fall, lw, hw;
  bit  rise_ok, fall_ok;

  glitchless_clk_switch u_dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel_i),
    .clk_o (clk_o),
    .busy_o(busy_o)
  );

  initial clk_i = '0;
  always #2   clk_i[0] = ~clk_i[0];
  always #4.5 clk_i[1] = ~clk_i[1];
  always #7   clk_i[2] = ~clk_i[2];

  function automatic real half_ns(int s);
    case (s)
      0:       return 2.0;
      1:       return 4.5;
      default: return 7.0;
    endcase
  endfunction

  function automatic real per_ns(int s);
    return 2.0 * half_ns(s);
  endfunction

  function automatic real rmin(real a, real b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string req, string what, real act, real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  // Edge monitor: phase widths and pauses
  always @(posedge clk_o) begin
    if (rst_ni && fall_ok) begin
      lw = $realtime - t_fall;
      if (lw > 20.0) begin
        pause_cnt++;
        last_pause = lw;
      end else begin
        chk(lw >= floor_w - 0.01, "R2", "low phase width", lw, floor_w);
      end
    end
    t_rise  = $realtime;
    rise_ok = rst_ni;
  end

  always @(negedge clk_o) begin
    if (rst_ni && rise_ok) begin
      hw = $realtime - t_rise;
      chk(hw >= floor_w - 0.01, "R2", "high phase width", hw, floor_w);
    end
    t_fall  = $realtime;
    fall_ok = rst_ni;
  end

  task automatic measure(output real p);
    real t1;
    @(posedge clk_o);
    t1 = $realtime;
    @(posedge clk_o);
    p = $realtime - t1;
    #0.25;
  endtask

  task automatic wait_idle(int limit);
    for (int k = 0; k < limit; k++) begin
      if (!busy_o) break;
      #1;
    end
  endtask

  task automatic do_switch(int n);
    int  pc0;
    real p;
    pc0     = pause_cnt;
    floor_w = rmin(half_ns(cur), half_ns(n));
    sel_i   = 2'(n);
    #14;
    chk(busy_o == 1'b1, "R5", "busy after select change", real'(busy_o), 1.0);
    wait_idle(2000);
    chk(busy_o == 1'b0, "R5", "busy released", real'(busy_o), 0.0);
    chk(pause_cnt == pc0 + 1, "R5", "restart seen before busy release", real'(pause_cnt), real'(pc0 + 1));
    chk(last_pause >= 8.0 * per_ns(n) - 0.01 && last_pause <= 9.0 * per_ns(n) + 0.01,
        "R3", "pause length", last_pause, 8.5 * per_ns(n));
    cur = n;
    measure(p);
    chk(p > per_ns(n) - 0.01 && p < per_ns(n) + 0.01, "R4", "period after switch", p, per_ns(n));
    floor_w = half_ns(n);
  endtask

  task automatic do_same();
    int pc0;
    pc0   = pause_cnt;
    sel_i = 2'(cur);
    #20;
    chk(busy_o == 1'b0, "R7", "busy on same select", real'(busy_o), 0.0);
    #80;
    chk(pause_cnt == pc0, "R7", "no pause on same select", real'(pause_cnt), real'(pc0));
  endtask

  task automatic do_invalid();
    int  pc0;
    real p;
    pc0   = pause_cnt;
    sel_i = 2'd3;
    #20;
    chk(busy_o == 1'b0, "R8", "busy on invalid code", real'(busy_o), 0.0);
    #100;
    chk(pause_cnt == pc0, "R8", "no pause on invalid code", real'(pause_cnt), real'(pc0));
    measure(p);
    chk(p > per_ns(cur) - 0.01 && p < per_ns(cur) + 0.01, "R8", "period kept on invalid code", p, per_ns(cur));
    sel_i = 2'(cur);
    #20;
  endtask

  task automatic do_pending(int a, int b);
    int  pc0;
    real p;
    pc0     = pause_cnt;
    floor_w = rmin(half_ns(cur), rmin(half_ns(a), half_ns(b)));
    sel_i   = 2'(a);
    #14;
    chk(busy_o == 1'b1, "R6", "busy on first request", real'(busy_o), 1.0);
    #16;
    chk(busy_o == 1'b1, "R6", "still busy at second request", real'(busy_o), 1.0);
    sel_i = 2'(b);
    #3000;
    chk(busy_o == 1'b0, "R6", "idle after both switches", real'(busy_o), 0.0);
    chk(pause_cnt == pc0 + 2, "R6", "two separate pauses", real'(pause_cnt), real'(pc0 + 2));
    cur = b;
    measure(p);
    chk(p > per_ns(b) - 0.01 && p < per_ns(b) + 0.01, "R6", "period of later request", p, per_ns(b));
    floor_w = half_ns(b);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    real p;
    checks = 0; errors = 0; pause_cnt = 0; cur = 0;
    rise_ok = 0; fall_ok = 0; floor_w = 2.0;
    t_rise = 0.0; t_fall = 0.0; last_pause = 0.0;
    rst_ni = 1'b0;
    sel_i  = 2'd0;
    void'($urandom(32'h5eed));
    #20.25;
    chk(busy_o == 1'b0, "R1", "busy during reset", real'(busy_o), 0.0);
    rst_ni = 1'b1;
    #1;
    chk(busy_o == 1'b0, "R1", "busy after reset", real'(busy_o), 0.0);
    measure(p);
    chk(p > 3.99 && p < 4.01, "R1", "default source period", p, 4.0);
    #50;
    chk(pause_cnt == 0, "R1", "no pause after reset", real'(pause_cnt), 0.0);

    do_switch(1);
    do_switch(2);
    do_switch(0);
    do_switch(2);
    do_same();
    do_invalid();
    do_pending(1, 0);
    do_pending(2, 1);

    for (int it = 0; it < 12; it++) begin
      int n;
      n = int'($urandom_range(0, 2));
      if (n == cur) do_same();
      else          do_switch(n);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule